// File: doc/BRIEF.md
# Activity Event Serial Packet Reporter

This block collects system activity events into an 8-bit packet. It sends that packet one bit at a time to an external power-management companion over a data line and a clock line. The events are:

- a vertical sync pulse;
- a level-1 cache miss, which carries a read/write qualifier and an instruction-fetch qualifier;
- a video or graphics access;
- a memory access whose address falls inside a programmable base/mask window.

Separate enable bits qualify the cache-miss and video events. Events stay in the packet until a transmission sends them. The packet is then cleared.

A transmission starts in one of two ways. The periodic way uses an interval timer. The timer counts 1 ms ticks, which a parameterised divider derives from the system clock. When the timer expires, the block sends only if the packet holds at least one set bit. The direct way is a write-only test bit in the control word, which forces an immediate send. While a shift is in progress, the busy flag blocks every new request, and events that arrive are held back. The held events are merged into the packet in the same cycle that the sent bits are cleared.

The serializer is a four-state machine:

- **SH_IDLE**: not sending.
- **SH_LOW**: drives the current bit with the serial clock low.
- **SH_HIGH**: keeps the bit and raises the serial clock.
- **SH_DONE**: a one-cycle state that clears the packet.

Its transitions are:

- *start*: SH_IDLE to SH_LOW.
- *rise*: SH_LOW to SH_HIGH, after SER_DIV cycles.
- *next bit*: SH_HIGH to SH_LOW, after SER_DIV cycles while bits remain.
- *last bit*: SH_HIGH to SH_DONE.
- *finish*: SH_DONE to SH_IDLE.

Top module: `activity_packet_tx`

## Requirements
- R1: After reset, `packet`, `busy`, `ser_clk`, `ser_data` and `ctrl_rd` are all zero.
- R2: A write with `wr_sel`=0 loads the control word. Its bits are: bit 0 video enable, bit 1 miss master enable, bit 2 read-miss enable, bits 4:3 interval, bit 5 test. `ctrl_rd` returns bits 4:0 as written, and bit 5 of `ctrl_rd` is always 0.
- R3: Packet bit 6 is set by a cache miss that is not an instruction fetch, and only while the master enable is 1. A write miss (`l1_miss_wr`=1) needs only the master enable. A read miss also needs the read-miss enable. The read-miss enable alone sets nothing.
- R4: Packet bit 0 is set by `gfx_access` only while the video enable is 1.
- R5: Packet bit 7 is set by `vsync_pulse`, with no enable.
- R6: Packet bit 1 is set when `mem_valid` is high and (`mem_addr` & mask) == (base & mask). A write with `wr_sel`=1 loads the base and a write with `wr_sel`=2 loads the mask, each AW bits wide.
- R7: Packet bits 5:2 are always 0.
- R8: A transmission sends the 8 packet bits MSB first. Each bit is held on `ser_data` for SER_DIV cycles with `ser_clk` low, then for SER_DIV cycles with `ser_clk` high. The receiver samples on the rising edge.
- R9: When a transmission completes, the packet is cleared. The packet does not change while `busy` is high. Events that arrive during the send appear in the packet after the clear.
- R10: Interval code 00 stops the timer. Codes 01, 10 and 11 give a period of 1, 5 and 10 ticks, where one tick is TICK_DIV cycles. Any control write restarts the timer.
- R11: When the timer expires, a send starts only if the packet is non-zero.
- R12: Writing the control word with bit 5 set starts a send of the current packet at once, whatever the interval code.
- R13: While `busy` is high, any new send request (periodic or test) is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vsync_pulse | input | 1 | Vertical sync event strobe |
| l1_miss | input | 1 | Level-1 cache miss strobe |
| l1_miss_wr | input | 1 | Miss qualifier: 1 = write, 0 = read |
| l1_miss_ifetch | input | 1 | Miss qualifier: caused by an instruction fetch |
| gfx_access | input | 1 | Video or graphics access strobe |
| mem_valid | input | 1 | Memory address strobe |
| mem_addr | input | AW | Memory address to match against the window |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 control, 1 base, 2 mask |
| wr_data | input | AW | Register write data |
| ser_clk | output | 1 | Serial clock |
| ser_data | output | 1 | Serial data, MSB first |
| busy | output | 1 | A transmission is in progress |
| packet | output | 8 | Current packet contents |
| ctrl_rd | output | 6 | Control word readback (bit 5 always 0) |

## Verification
Timing of each result:

- **Event strobes:** an event strobe sampled at a clock edge shows in `packet` after that same edge. The bench drives on the falling edge and compares on the next falling edge.
- **Test write:** a test write moves `busy` high on the edge that takes the write. The serial bits are then captured on each rising `ser_clk`, at which point `ser_data` has been stable for SER_DIV cycles. The clear follows 16·SER_DIV+1 cycles after the start and is checked once `busy` falls.
- **Periodic send:** a periodic send begins exactly period·TICK_DIV cycles after the control write. A counter of `busy` rises is checked a few cycles before that edge and a few cycles after it, so the boundary is bracketed.

// File: rtl/apkt_pkg.sv
package apkt_pkg;

    localparam int PKT_W     = 8;

    // control word fields
    localparam int CTL_VID   = 0;
    localparam int CTL_MISS  = 1;
    localparam int CTL_RD    = 2;
    localparam int CTL_PER   = 3;
    localparam int CTL_TEST  = 5;
    localparam int CTL_W     = 5;

    // register selects
    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_BASE = 2'd1;
    localparam logic [1:0] SEL_MASK = 2'd2;

    // packet bit positions
    localparam int PB_VSYNC  = 7;
    localparam int PB_MISS   = 6;
    localparam int PB_ADDR   = 1;
    localparam int PB_VIDEO  = 0;

    typedef enum logic [1:0] {
        SH_IDLE,
        SH_LOW,
        SH_HIGH,
        SH_DONE
    } shift_state_e;

endpackage

// File: rtl/apkt_timer.sv
module apkt_timer
    import apkt_pkg::*;
#(
    parameter int TICK_DIV = 125000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart_i,
    input  logic [1:0] sel_i,
    output logic       expire_o
);

    localparam int TW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    logic [TW-1:0] tick_q;
    logic [3:0]    ms_q;
    logic          tick;
    logic [3:0]    last_ms;

    always_comb begin
        tick = (tick_q == TW'(TICK_DIV - 1));
        unique case (sel_i)
            2'b01:   last_ms = 4'd0;
            2'b10:   last_ms = 4'd4;
            2'b11:   last_ms = 4'd9;
            default: last_ms = 4'd0;
        endcase
        expire_o = tick && (sel_i != 2'b00) && (ms_q == last_ms);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_q <= '0;
            ms_q   <= '0;
        end else if (restart_i) begin
            tick_q <= '0;
            ms_q   <= '0;
        end else begin
            tick_q <= tick ? '0 : tick_q + 1'b1;
            if (sel_i == 2'b00)
                ms_q <= '0;
            else if (tick)
                ms_q <= expire_o ? 4'd0 : ms_q + 4'd1;
        end
    end

    // R10
    restart_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> !expire_o);

endmodule

// File: rtl/apkt_collect.sv
module apkt_collect
    import apkt_pkg::*;
#(
    parameter int AW = 27
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vid_en_i,
    input  logic             miss_en_i,
    input  logic             rd_en_i,
    input  logic             vsync_i,
    input  logic             miss_i,
    input  logic             miss_wr_i,
    input  logic             miss_if_i,
    input  logic             gfx_i,
    input  logic             mem_valid_i,
    input  logic [AW-1:0]    mem_addr_i,
    input  logic [AW-1:0]    base_i,
    input  logic [AW-1:0]    mask_i,
    input  logic             hold_i,
    input  logic             clr_i,
    output logic [PKT_W-1:0] pkt_o
);

    logic [PKT_W-1:0] ev;
    logic [PKT_W-1:0] pend_q;
    logic [PKT_W-1:0] pkt_q;

    always_comb begin
        ev           = '0;
        ev[PB_VSYNC] = vsync_i;
        ev[PB_MISS]  = miss_i && miss_en_i && !miss_if_i && (miss_wr_i || rd_en_i);
        ev[PB_ADDR]  = mem_valid_i && (((mem_addr_i ^ base_i) & mask_i) == '0);
        ev[PB_VIDEO] = gfx_i && vid_en_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pkt_q  <= '0;
            pend_q <= '0;
        end else if (clr_i) begin
            pkt_q  <= pend_q | ev;
            pend_q <= '0;
        end else if (hold_i) begin
            pend_q <= pend_q | ev;
        end else begin
            pkt_q  <= pkt_q | ev;
        end
    end

    assign pkt_o = pkt_q;

    // R9
    frozen_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_i && !clr_i) |=> $stable(pkt_o));

    // R9
    clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && pend_q == '0 && ev == '0) |=> (pkt_o == '0));

endmodule

// File: rtl/apkt_shift.sv
module apkt_shift
    import apkt_pkg::*;
#(
    parameter int SER_DIV = 4,
    parameter int W       = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [W-1:0] data_i,
    output logic         busy_o,
    output logic         clr_o,
    output logic         sclk_o,
    output logic         sdata_o
);

    localparam int CW = (SER_DIV > 1) ? $clog2(SER_DIV) : 1;
    localparam int IW = (W > 1) ? $clog2(W) : 1;

    shift_state_e  state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic [IW-1:0] idx_q;
    logic [W-1:0]  sh_q;
    logic          phase_end;

    assign phase_end = (cnt_q == CW'(SER_DIV - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SH_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SH_IDLE: if (start_i)   state_d = SH_LOW;
            SH_LOW:  if (phase_end) state_d = SH_HIGH;
            SH_HIGH: if (phase_end) state_d = (idx_q == '0) ? SH_DONE : SH_LOW;
            SH_DONE:                state_d = SH_IDLE;
            default:                state_d = SH_IDLE;
        endcase
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            idx_q <= '0;
            sh_q  <= '0;
        end else begin
            unique case (state_q)
                SH_IDLE: if (start_i) begin
                    sh_q  <= data_i;
                    idx_q <= IW'(W - 1);
                    cnt_q <= '0;
                end
                SH_LOW:  cnt_q <= phase_end ? '0 : cnt_q + 1'b1;
                SH_HIGH: begin
                    cnt_q <= phase_end ? '0 : cnt_q + 1'b1;
                    if (phase_end && idx_q != '0) begin
                        sh_q  <= sh_q << 1;
                        idx_q <= idx_q - 1'b1;
                    end
                end
                SH_DONE: cnt_q <= '0;
                default: cnt_q <= '0;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy_o  = (state_q != SH_IDLE);
        clr_o   = (state_q == SH_DONE);
        sclk_o  = (state_q == SH_HIGH);
        sdata_o = ((state_q == SH_LOW) || (state_q == SH_HIGH)) ? sh_q[W-1] : 1'b0;
    end

    // R8
    sdata_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SH_HIGH) |-> $stable(sdata_o));

    // R8
    done_after_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SH_DONE) |-> ($past(state_q) == SH_HIGH));

endmodule

// File: rtl/activity_packet_tx.sv
module activity_packet_tx
    import apkt_pkg::*;
#(
    parameter int TICK_DIV = 125000,
    parameter int SER_DIV  = 4,
    parameter int AW       = 27
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          vsync_pulse,
    input  logic          l1_miss,
    input  logic          l1_miss_wr,
    input  logic          l1_miss_ifetch,
    input  logic          gfx_access,
    input  logic          mem_valid,
    input  logic [AW-1:0] mem_addr,
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [AW-1:0] wr_data,
    output logic          ser_clk,
    output logic          ser_data,
    output logic          busy,
    output logic [7:0]    packet,
    output logic [5:0]    ctrl_rd
);

    logic [CTL_W-1:0] ctrl_q;
    logic [AW-1:0]    base_q;
    logic [AW-1:0]    mask_q;
    logic             ctrl_wr;
    logic             test_wr;
    logic             expire;
    logic             clr;
    logic             send_go;

    assign ctrl_wr = wr_en && (wr_sel == SEL_CTRL);
    assign test_wr = ctrl_wr && wr_data[CTL_TEST];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            base_q <= '0;
            mask_q <= '0;
        end else if (wr_en) begin
            unique case (wr_sel)
                SEL_CTRL: ctrl_q <= wr_data[CTL_W-1:0];
                SEL_BASE: base_q <= wr_data;
                SEL_MASK: mask_q <= wr_data;
                default:  ;
            endcase
        end
    end

    assign ctrl_rd = {1'b0, ctrl_q};

    apkt_timer #(.TICK_DIV(TICK_DIV)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (ctrl_wr),
        .sel_i     (ctrl_q[CTL_PER+1:CTL_PER]),
        .expire_o  (expire)
    );

    apkt_collect #(.AW(AW)) u_collect (
        .clk         (clk),
        .rst_n       (rst_n),
        .vid_en_i    (ctrl_q[CTL_VID]),
        .miss_en_i   (ctrl_q[CTL_MISS]),
        .rd_en_i     (ctrl_q[CTL_RD]),
        .vsync_i     (vsync_pulse),
        .miss_i      (l1_miss),
        .miss_wr_i   (l1_miss_wr),
        .miss_if_i   (l1_miss_ifetch),
        .gfx_i       (gfx_access),
        .mem_valid_i (mem_valid),
        .mem_addr_i  (mem_addr),
        .base_i      (base_q),
        .mask_i      (mask_q),
        .hold_i      (busy),
        .clr_i       (clr),
        .pkt_o       (packet)
    );

    assign send_go = !busy && (test_wr || (expire && (packet != '0)));

    apkt_shift #(.SER_DIV(SER_DIV), .W(PKT_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (send_go),
        .data_i  (packet),
        .busy_o  (busy),
        .clr_o   (clr),
        .sclk_o  (ser_clk),
        .sdata_o (ser_data)
    );

    // R11
    nonempty_or_test_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(packet != '0) || $past(test_wr)));

    // R8
    sclk_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ser_clk |-> busy);

endmodule

// File: tb/sim_activity_packet_tx.sv
module sim_activity_packet_tx;

    localparam int AW   = 27;
    localparam int TDIV = 10;
    localparam int SDIV = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          vsync_pulse = 1'b0;
    logic          l1_miss = 1'b0;
    logic          l1_miss_wr = 1'b0;
    logic          l1_miss_ifetch = 1'b0;
    logic          gfx_access = 1'b0;
    logic          mem_valid = 1'b0;
    logic [AW-1:0] mem_addr = '0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_sel = 2'd0;
    logic [AW-1:0] wr_data = '0;
    logic          ser_clk, ser_data, busy;
    logic [7:0]    packet;
    logic [5:0]    ctrl_rd;

    int n_chk  = 0;
    int n_fail = 0;
    int rises  = 0;
    logic busy_prev = 1'b0;

    always #4 clk = ~clk;

    activity_packet_tx #(.TICK_DIV(TDIV), .SER_DIV(SDIV), .AW(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .vsync_pulse(vsync_pulse), .l1_miss(l1_miss),
        .l1_miss_wr(l1_miss_wr), .l1_miss_ifetch(l1_miss_ifetch),
        .gfx_access(gfx_access), .mem_valid(mem_valid), .mem_addr(mem_addr),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .ser_clk(ser_clk),
        .ser_data(ser_data), .busy(busy), .packet(packet), .ctrl_rd(ctrl_rd)
    );

    always @(negedge clk) begin
        if (busy && !busy_prev) rises = rises + 1;
        busy_prev = busy;
    end

    // vector: [15] vid_en [14] miss_en [13] rd_en [12] miss [11] miss_wr
    //         [10] ifetch [9] gfx [8] vsync [7:0] expected packet
    localparam int NV = 10;
    localparam logic [15:0] VEC [NV] = '{
        16'b000_1_1_0_0_0_00000000,  // R3 master off, write miss
        16'b010_1_1_0_0_0_01000000,  // R3 write miss, master on
        16'b010_1_0_0_0_0_00000000,  // R3 read miss, no read enable
        16'b011_1_0_0_0_0_01000000,  // R3 read miss, both enables
        16'b001_1_0_0_0_0_00000000,  // R3 read enable alone
        16'b011_1_1_1_0_0_00000000,  // R3 instruction fetch miss
        16'b100_0_0_0_1_0_00000001,  // R4 video enabled
        16'b000_0_0_0_1_0_00000000,  // R4 video disabled
        16'b000_0_0_0_0_1_10000000,  // R5 vsync
        16'b111_1_0_0_1_1_11000001   // R3 R4 R5 combined
    };

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [AW-1:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic send_capture(input logic [4:0] ctl, output logic [7:0] got);
        wr(2'd0, AW'({1'b1, ctl}));
        for (int b = 0; b < 8; b++) begin
            @(posedge ser_clk);
            got = {got[6:0], ser_data};
        end
        while (busy) @(negedge clk);
    endtask

    initial begin
        logic [7:0] got;
        int r0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 packet", packet, 0);
        check("R1 busy", busy, 0);
        check("R1 ser_clk", ser_clk, 0);
        check("R1 ser_data", ser_data, 0);
        check("R1 ctrl_rd", ctrl_rd, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // vector table: gating, serial format, clear
        for (int i = 0; i < NV; i++) begin
            logic [4:0] ctl;
            ctl = {2'b00, VEC[i][13], VEC[i][14], VEC[i][15]};
            wr(2'd0, AW'(ctl));
            l1_miss = VEC[i][12]; l1_miss_wr = VEC[i][11];
            l1_miss_ifetch = VEC[i][10]; gfx_access = VEC[i][9];
            vsync_pulse = VEC[i][8];
            @(negedge clk);
            l1_miss = 0; l1_miss_wr = 0; l1_miss_ifetch = 0;
            gfx_access = 0; vsync_pulse = 0;
            check($sformatf("R3/R4/R5/R7 vec%0d packet", i), packet, VEC[i][7:0]);
            if (VEC[i][7:0] != 0) begin
                got = '0;
                send_capture(ctl, got);
                check($sformatf("R8 R12 vec%0d serial", i), got, VEC[i][7:0]);
                check($sformatf("R9 vec%0d cleared", i), packet, 0);
            end
        end

        // R2 readback, test bit reads 0
        wr(2'd0, AW'(6'b111011));
        check("R2 ctrl_rd", ctrl_rd, 6'b011011);
        while (busy) @(negedge clk);
        wr(2'd0, AW'(0));

        // R6 address window
        wr(2'd1, AW'(27'h2345000));
        wr(2'd2, AW'(27'h7FFF000));
        mem_valid = 1; mem_addr = 27'h2345ABC;
        @(negedge clk); mem_valid = 0;
        check("R6 match", packet, 8'h02);
        got = '0;
        send_capture(5'd0, got);
        check("R8 addr serial", got, 8'h02);
        mem_valid = 1; mem_addr = 27'h2346000;
        @(negedge clk); mem_valid = 0;
        check("R6 outside window", packet, 0);
        mem_addr = 27'h2345000;
        @(negedge clk);
        check("R6 strobe low", packet, 0);
        wr(2'd2, AW'(0));
        mem_valid = 1; mem_addr = 27'h0000001;
        @(negedge clk); mem_valid = 0;
        check("R6 zero mask", packet, 8'h02);
        send_capture(5'd0, got);

        // R9 events during send are held
        vsync_pulse = 1; @(negedge clk); vsync_pulse = 0;
        wr(2'd0, AW'(6'b100000));
        repeat (3) @(negedge clk);
        l1_miss = 1; l1_miss_wr = 1;
        @(negedge clk); l1_miss = 0; l1_miss_wr = 0;
        vsync_pulse = 1; @(negedge clk); vsync_pulse = 0;
        check("R9 frozen while busy", packet, 8'h80);
        while (busy) @(negedge clk);
        check("R9 held events applied", packet, 8'h80);
        send_capture(5'd0, got);
        check("R9 cleared again", packet, 0);

        // R13 second test write during busy is dropped
        r0 = rises;
        vsync_pulse = 1; @(negedge clk); vsync_pulse = 0;
        wr(2'd0, AW'(6'b100000));
        wr(2'd0, AW'(6'b100000));
        while (busy) @(negedge clk);
        repeat (5) @(negedge clk);
        check("R13 one send only", rises, r0 + 1);
        check("R13 packet empty", packet, 0);

        // R11 periodic with empty packet sends nothing
        r0 = rises;
        wr(2'd0, AW'(5'b01000));
        repeat (60) @(negedge clk);
        check("R11 no send when empty", rises, r0);
        vsync_pulse = 1; @(negedge clk); vsync_pulse = 0;
        repeat (12) @(negedge clk);
        check("R11 send when non-empty", rises, r0 + 1);
        while (busy) @(negedge clk);
        check("R11 cleared", packet, 0);

        // R10 period 5 ticks
        wr(2'd0, AW'(0));
        vsync_pulse = 1; @(negedge clk); vsync_pulse = 0;
        r0 = rises;
        wr(2'd0, AW'(5'b10000));
        repeat (44) @(negedge clk);
        check("R10 5ms not early", rises, r0);
        repeat (10) @(negedge clk);
        check("R10 5ms on time", rises, r0 + 1);
        while (busy) @(negedge clk);

        // R10 period 10 ticks with restart
        wr(2'd0, AW'(0));
        vsync_pulse = 1; @(negedge clk); vsync_pulse = 0;
        r0 = rises;
        wr(2'd0, AW'(5'b11000));
        repeat (40) @(negedge clk);
        wr(2'd0, AW'(5'b11000));
        repeat (94) @(negedge clk);
        check("R10 restart delays expiry", rises, r0);
        repeat (10) @(negedge clk);
        check("R10 10ms on time", rises, r0 + 1);
        while (busy) @(negedge clk);

        // R10 code 00 stops timer
        wr(2'd0, AW'(0));
        vsync_pulse = 1; @(negedge clk); vsync_pulse = 0;
        r0 = rises;
        repeat (150) @(negedge clk);
        check("R10 off no send", rises, r0);
        check("R7 reserved zero", packet & 8'h3C, 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog R1 actual=hung expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule